// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Control

This block is the digital half of a 12-bit successive-approximation converter with a three-wire read port. It runs on a fast system clock. An active-low select input and an external shift clock come in asynchronously, and a single data output goes back to the host. When the select line falls, the block drives the hold control and starts an internally timed conversion. During the conversion it presents a trial code to the capacitive DAC and reads back a one-bit comparator decision, one bit per system clock, from bit 11 down to bit 0. The total conversion window is a fixed number of system clocks that covers 8.5 µs.

The data line frames itself. While the part is deselected, the output driver is off. From the start of the conversion the line is driven low. At the end of the conversion it goes high, and this high level is both the end-of-conversion flag and a leading 1. After that, each falling edge of the shift clock presents the next result bit, MSB first, followed by zeros for as long as the host keeps clocking. Raising the select line at any point returns the block to idle, which also aborts a conversion that is in progress.

The controller has four states. IDLE goes to CONVERT on a select fall. CONVERT goes to FLAG when the conversion window expires. FLAG goes to SHIFT on the first shift-clock fall. SHIFT stays in SHIFT on each further fall. Every state goes back to IDLE whenever the synchronised select is high.

Top module: `sar_serial_ctrl`

## Requirements
- R1: While the synchronised select is high, and after reset, `dout_en` is 0 (the output is high impedance).
- R2: A falling select edge starts a conversion. From then until the conversion ends, `dout_en`=1, `dout`=0 and `hold`=1.
- R3: `hold` stays high for exactly CONV_CYCLES = ceil(SYS_CLK_MHZ*CONV_TIME_NS/1000) system clocks. This is 1063 at the defaults, and the count does not depend on the shift clock.
- R4: When the conversion window ends, `dout` goes to 1 and stays at 1 until the first synchronised shift-clock fall.
- R5: Each shift-clock fall after the flag presents the next result bit. Bit 11 comes first and bit 0 comes on the twelfth fall. The result is straight binary.
- R6: Every shift-clock fall after the twelfth, while select stays low, presents 0.
- R7: Shift-clock falls during the conversion are ignored. The line stays low, and the first fall after the flag still presents bit 11.
- R8: Raising select during a conversion aborts it: `hold` and `dout_en` drop. The next select fall starts a full, fresh conversion.
- R9: The trial code `dac_code` starts at midscale (0x800). Each step keeps the trial bit when `comp_in`=1 (trial at or below the input) and clears it otherwise. The result therefore equals the input level that the comparator reflects.
- R10: Select and shift clock each pass through two synchroniser flops. An input edge changes the outputs after the third system-clock rising edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select, asynchronous |
| sclk | input | 1 | External shift clock, asynchronous, idles low |
| comp_in | input | 1 | Comparator decision: 1 when the trial code is at or below the input |
| dac_code | output | DATA_W | Trial code driven to the DAC |
| hold | output | 1 | Track/hold control, 1 = hold |
| dout | output | 1 | Serial data value |
| dout_en | output | 1 | Output driver enable, 0 = high impedance |

## Verification
Outputs respond on the third system-clock rising edge after a select or shift-clock edge, because there are two synchroniser stages and the state register. The bench's behavioural model therefore works on input samples delayed by two and three clocks. It compares `dout`, `dout_en` and `hold` at every falling clock edge. Directed checks add further detail. Enable must still be low two edges after the select fall and high after the third. The hold window is counted to exactly CONV_CYCLES clocks. Each serial bit is sampled eight system clocks after its shift-clock fall, which is well after its three-edge latency and before the next fall.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_FLAG,
        ST_SHIFT
    } sar_state_e;

    function automatic int conv_cycles(input int clk_mhz, input int time_ns);
        return (clk_mhz * time_ns + 999) / 1000;
    endfunction
endpackage

// File: rtl/sar_sync_edge.sv
module sar_sync_edge #(
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic fell
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RESET_VAL;
            sync_q <= RESET_VAL;
            prev_q <= RESET_VAL;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign fell  = prev_q & ~sync_q;
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step_en,
    input  logic              comp_in,
    output logic [DATA_W-1:0] code
);
    localparam int PTR_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [PTR_W-1:0]  ptr_q;
    logic              busy_q;
    logic [DATA_W-1:0] code_q, code_nxt;

    always_comb begin
        code_nxt = code_q;
        if (!comp_in)
            code_nxt[ptr_q] = 1'b0;
        if (ptr_q != '0)
            code_nxt[ptr_q - 1'b1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            ptr_q  <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            code_q <= {1'b1, {(DATA_W-1){1'b0}}};
            ptr_q  <= PTR_W'(DATA_W - 1);
            busy_q <= 1'b1;
        end else if (step_en && busy_q) begin
            code_q <= code_nxt;
            ptr_q  <= ptr_q - 1'b1;
            if (ptr_q == '0)
                busy_q <= 1'b0;
        end
    end

    assign code = code_q;
endmodule

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl
    import sar_pkg::*;
#(
    parameter int DATA_W       = 12,
    parameter int SYS_CLK_MHZ  = 125,
    parameter int CONV_TIME_NS = 8500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              comp_in,
    output logic [DATA_W-1:0] dac_code,
    output logic              hold,
    output logic              dout,
    output logic              dout_en
);
    localparam int CONV_CYCLES = conv_cycles(SYS_CLK_MHZ, CONV_TIME_NS);
    localparam int CNT_W       = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

    sar_state_e        state_q, state_nxt;
    logic [CNT_W-1:0]  conv_cnt_q;
    logic [DATA_W-1:0] shift_q;
    logic              cs_lvl, cs_fall, sclk_lvl, sclk_fall;
    logic              sar_start;

    sar_sync_edge #(.RESET_VAL(1'b1)) cs_sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(cs_n), .level(cs_lvl), .fell(cs_fall)
    );

    sar_sync_edge #(.RESET_VAL(1'b0)) sclk_sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(sclk), .level(sclk_lvl), .fell(sclk_fall)
    );

    sar_engine #(.DATA_W(DATA_W)) engine_i (
        .clk(clk), .rst_n(rst_n), .start(sar_start),
        .step_en(state_q == ST_CONVERT), .comp_in(comp_in), .code(dac_code)
    );

    // Next-state logic; select high returns to IDLE from every state.
    always_comb begin
        state_nxt = state_q;
        if (cs_lvl) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (cs_fall)               state_nxt = ST_CONVERT;
                ST_CONVERT: if (conv_cnt_q == CNT_LAST) state_nxt = ST_FLAG;
                ST_FLAG:    if (sclk_fall)             state_nxt = ST_SHIFT;
                ST_SHIFT:                              state_nxt = ST_SHIFT;
            endcase
        end
    end

    assign sar_start = (state_q == ST_IDLE) && (state_nxt == ST_CONVERT);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_nxt;
    end

    // Conversion timer and output shifter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_cnt_q <= '0;
            shift_q    <= '0;
        end else begin
            if (state_q == ST_CONVERT)
                conv_cnt_q <= conv_cnt_q + 1'b1;
            else
                conv_cnt_q <= '0;
            if (state_q == ST_FLAG && state_nxt == ST_SHIFT)
                shift_q <= dac_code;
            else if (state_q == ST_SHIFT && sclk_fall)
                shift_q <= {shift_q[DATA_W-2:0], 1'b0};
        end
    end

    // Outputs decoded from state.
    always_comb begin
        hold    = 1'b0;
        dout    = 1'b0;
        dout_en = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_CONVERT: begin hold = 1'b1; dout_en = 1'b1; end
            ST_FLAG:    begin dout = 1'b1; dout_en = 1'b1; end
            ST_SHIFT:   begin dout = shift_q[DATA_W-1]; dout_en = 1'b1; end
        endcase
    end

    logic unused_sclk_lvl;
    assign unused_sclk_lvl = sclk_lvl;
endmodule

// File: rtl/sar_serial_chk.sv
module sar_serial_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_lvl,
    input logic              sclk_fall,
    input logic              hold,
    input logic              dout,
    input logic              dout_en,
    input logic [DATA_W-1:0] dac_code
);
    assert_hiz_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> !dout_en);

    assert_low_while_converting_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (dout_en && !dout));

    assert_eoc_flag_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold) && dout_en) |-> dout);

    assert_sclk_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && sclk_fall) |=> (hold || (dout_en && dout)));

    assert_abort_on_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && cs_lvl) |=> !hold);

    assert_midscale_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> (dac_code == {1'b1, {(DATA_W-1){1'b0}}}));
endmodule

bind sar_serial_ctrl sar_serial_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .sclk_fall(sclk_fall),
    .hold(hold), .dout(dout), .dout_en(dout_en), .dac_code(dac_code)
);

// File: tb/sar_serial_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_serial_ctrl_tb_top;
    localparam int W      = 12;
    localparam int NCONV  = 1063;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic [W-1:0] target = '0;
    logic [W-1:0] dac_code;
    logic         comp_in, hold, dout, dout_en;
    int           checks = 0;
    int           errors = 0;
    bit           done = 0;

    always #4 clk = ~clk;

    // Ideal comparator: 1 when the trial code is at or below the input level.
    assign comp_in = (dac_code <= target);

    sar_serial_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .comp_in(comp_in),
        .dac_code(dac_code), .hold(hold), .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model on delayed input samples.
    logic         csq[$];
    logic         sq[$];
    int           phase;      // 0 idle, 1 converting, 2 flag, 3 shifting
    int           left;
    int           nshift;
    logic [W-1:0] mdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            csq = {1'b1, 1'b1, 1'b1};
            sq  = {1'b0, 1'b0, 1'b0};
            phase = 0; left = 0; nshift = 0; mdata = '0;
        end else begin
            logic cs_old, cs_new, s_fall;
            cs_old = csq[0];
            cs_new = csq[1];
            s_fall = sq[0] && !sq[1];
            if (cs_new) begin
                phase = 0;
            end else begin
                case (phase)
                    0: if (cs_old) begin phase = 1; left = NCONV - 1; end
                    1: if (left == 0) phase = 2; else left--;
                    2: if (s_fall) begin phase = 3; mdata = target; nshift = 0; end
                    default: if (s_fall) begin mdata = mdata << 1; nshift++; end
                endcase
            end
            csq.push_back(cs_n);  void'(csq.pop_front());
            sq.push_back(sclk);   void'(sq.pop_front());
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            string tag;
            logic  exp_d;
            tag = (phase == 0) ? "R1 model" : (phase == 1) ? "R2 model" :
                  (phase == 2) ? "R4 model" : (nshift < W) ? "R5 model" : "R6 model";
            exp_d = (phase == 2) || (phase == 3 && mdata[W-1]);
            chk({tag, " en"},   dout_en, phase != 0);
            chk({tag, " hold"}, hold,    phase == 1);
            if (phase != 0) chk({tag, " dout"}, dout, exp_d);
        end
    end

    task automatic convert(input logic [W-1:0] t, input int falls, input bit noisy);
        int           hc;
        logic [W-1:0] rx;
        target = t;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 enable still off after two edges", dout_en, 0);
        @(negedge clk);
        chk("R10 enable on after third edge", dout_en, 1);
        chk("R2 hold at start", hold, 1);
        chk("R9 midscale trial", dac_code, 32'h800);
        hc = 1;
        while (1) begin
            @(negedge clk);
            if (!hold) break;
            hc++;
            if (noisy) sclk = (hc >= 40 && hc < 100) ? hc[3] : 1'b0;
            if (hc == 120) chk("R7 line low after ignored sclk", dout, 0);
        end
        chk("R3 conversion length", hc, NCONV);
        chk("R4 flag high", dout, 1);
        rx = '0;
        for (int k = 0; k < falls; k++) begin
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
            repeat (8) @(negedge clk);
            if (k < W) begin
                chk($sformatf("R5 bit %0d", W-1-k), dout, t[W-1-k]);
                rx[W-1-k] = dout;
            end else begin
                chk("R6 zero padding", dout, 0);
            end
        end
        if (falls >= W) chk("R9 result equals input", rx, t);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 high impedance after deselect", dout_en, 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 reset enable", dout_en, 0);
        chk("R1 reset hold", hold, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 idle enable", dout_en, 0);

        convert(12'hA5C, 13, 1'b0);
        convert(12'h000, 13, 1'b0);
        convert(12'hFFF, 16, 1'b0);
        convert(12'h801, 13, 1'b1);
        convert(12'h7FF, 15, 1'b1);

        // Abort mid conversion.
        target = 12'h555;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (200) @(negedge clk);
        chk("R8 converting before abort", hold, 1);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 hold dropped", hold, 0);
        chk("R8 driver off", dout_en, 0);
        repeat (4) @(negedge clk);
        convert(12'h3C3, 13, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule